// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that software reaches over a simple 32-bit register bus with an address, a write strobe and write data, plus a read strobe with read data. Software picks a timeout period that is a power of two and turns the timer on. After that it must keep writing a fixed restart key before the count runs out. Once the timer is on, software cannot turn it off again. Only a hardware reset does that.

When the count expires, what happens depends on the response mode. In the interrupt-first mode, the first expiry raises an interrupt. If that interrupt is still pending at the next expiry, the block asserts a system reset request. In the direct mode, the first expiry asserts the reset request at once and no interrupt is raised. The reset request is a pulse of fixed length. After the pulse, the counter starts a fresh period and the pending interrupt is cleared.

Inside, a thin top joins two modules. A control module decodes the bus, holds the configuration and runs the two expiry stages. A datapath module holds the down-counter and works out its reload value. The control drives the datapath through a small struct of strobes.

Top module: `wdt_two_stage`

## Requirements
- R1: After hardware reset, the control, range and status registers read 0, `irq` and `resetReq` are low, and the count register reads 2^BASE_SHIFT - 1.
- R2: Writing 1 to control bit 0 enables the timer, and no later write can clear that bit. Control bit 1 (response mode) stays freely writable.
- R3: While the timer is disabled, the counter holds at 2^(BASE_SHIFT+range) - 1, using the current range value, and neither `irq` nor `resetReq` is ever asserted.
- R4: The write that enables the timer loads the counter with P - 1, where P = 2^(BASE_SHIFT+range). The counter then drops by one each cycle. Expiry happens on the clock edge where the counter reads 0, which is P cycles after the enabling edge, and that edge reloads P - 1.
- R5: With control bit 1 set, an expiry while status bit 0 is clear sets status bit 0 (offset 0x10) and drives `irq` high.
- R6: With control bit 1 set, an expiry while status bit 0 is already set starts a reset request pulse.
- R7: With control bit 1 clear, an expiry starts a reset request pulse directly and `irq` never rises.
- R8: The reset request stays high for exactly PULSE_LEN cycles, and the counter holds at P - 1 while it does. When the pulse ends, status bit 0 is clear and a full period begins from P - 1.
- R9: Writing 0x76 to offset 0x0C reloads the counter with P - 1, and a restart on the same edge as a zero count takes priority over the expiry. Writing any other value to that offset changes nothing.
- R10: A read of offset 0x14 clears status bit 0, drops `irq` and reloads the counter with P - 1.
- R11: A write to the range register (offset 0x04, bits 3:0) leaves the running count alone. The new period applies from the next reload.
- R12: The register map is: control at 0x00 (bit 0 enable, bit 1 mode), range at 0x04, live count at 0x08, restart at 0x0C, status at 0x10 and end-of-interrupt at 0x14. The restart and end-of-interrupt offsets read as 0. Read data is combinational and reflects the state in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Expiry interrupt, high while status bit 0 is set |
| resetReq | output | 1 | System reset request pulse |

## Verification
The bench builds the block with BASE_SHIFT = 2, so the ranges 0 to 9 give periods from 4 to 2048 cycles. With periods that short, the bench can sweep every range value in both response modes and follow each counter trace cycle by cycle. In each sweep it times the interrupt, the second-stage reset and the pulse width against 2^(2+range) computed in the bench. PULSE_LEN keeps its default of 8.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_RANGE   = 'h04;
  localparam int OFS_COUNT   = 'h08;
  localparam int OFS_RESTART = 'h0C;
  localparam int OFS_STATUS  = 'h10;
  localparam int OFS_EOI     = 'h14;
  localparam logic [31:0] RESTART_KEY = 32'h0000_0076;

  typedef struct packed {
    logic reload;
    logic decrement;
  } cntStrobe_t;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT = 16,
  parameter int RANGE_W    = 4,
  parameter int CNT_W      = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         strobe,
  input  logic [RANGE_W-1:0] torr,
  output logic [CNT_W-1:0]   countVal,
  output logic               countZero
);
  localparam logic [CNT_W-1:0] RESET_LOAD = ~({CNT_W{1'b1}} << BASE_SHIFT);

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] countQ;

  // all ones below bit BASE_SHIFT+torr gives period-1
  assign reloadVal = ~({CNT_W{1'b1}} << (BASE_SHIFT + int'(torr)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= RESET_LOAD;
    end else if (strobe.reload) begin
      countQ <= reloadVal;
    end else if (strobe.decrement) begin
      countQ <= countQ - CNT_W'(1);
    end
  end

  assign countVal  = countQ;
  assign countZero = (countQ == '0);
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RANGE_W   = 4,
  parameter int CNT_W     = 31,
  parameter int PULSE_LEN = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  input  logic               busRdEn,
  output logic [31:0]        busRdData,
  input  logic [CNT_W-1:0]   countVal,
  input  logic               countZero,
  output cntStrobe_t         strobe,
  output logic [RANGE_W-1:0] torr,
  output logic               enable,
  output logic               respMode,
  output logic               irqPending,
  output logic               resetReq
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pulseLeft;
  logic wrCtrl, wrRange, restartHit, eoiHit;
  logic pulseActive, pulseEnd, expire, firstStage;

  assign wrCtrl     = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));
  assign wrRange    = busWrEn && (busAddr == ADDR_W'(OFS_RANGE));
  assign restartHit = busWrEn && (busAddr == ADDR_W'(OFS_RESTART)) && (busWrData == RESTART_KEY);
  assign eoiHit     = busRdEn && (busAddr == ADDR_W'(OFS_EOI));

  assign pulseActive = (pulseLeft != '0);
  assign pulseEnd    = (pulseLeft == PW'(1));
  // a restart or acknowledge on the zero edge wins over the expiry
  assign expire      = enable && !pulseActive && countZero && !restartHit && !eoiHit;
  assign firstStage  = respMode && !irqPending;

  always_comb begin
    strobe.reload    = !enable || pulseActive || restartHit || eoiHit || expire;
    strobe.decrement = !strobe.reload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable     <= 1'b0;
      respMode   <= 1'b0;
      torr       <= '0;
      irqPending <= 1'b0;
      pulseLeft  <= '0;
    end else begin
      if (wrCtrl) begin
        enable   <= enable | busWrData[0];
        respMode <= busWrData[1];
      end
      if (wrRange) begin
        torr <= busWrData[RANGE_W-1:0];
      end
      if (pulseEnd || eoiHit) begin
        irqPending <= 1'b0;
      end else if (expire && firstStage) begin
        irqPending <= 1'b1;
      end
      if (expire && !firstStage) begin
        pulseLeft <= PW'(PULSE_LEN);
      end else if (pulseActive) begin
        pulseLeft <= pulseLeft - PW'(1);
      end
    end
  end

  assign resetReq = pulseActive;

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        ADDR_W'(OFS_CTRL):   busRdData = {30'd0, respMode, enable};
        ADDR_W'(OFS_RANGE):  busRdData = 32'(torr);
        ADDR_W'(OFS_COUNT):  busRdData = 32'(countVal);
        ADDR_W'(OFS_STATUS): busRdData = {31'd0, irqPending};
        default:             busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int BASE_SHIFT = 16,
  parameter int RANGE_W    = 4,
  parameter int ADDR_W     = 8,
  parameter int PULSE_LEN  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              irq,
  output logic              resetReq
);
  localparam int CNT_W = BASE_SHIFT + (1 << RANGE_W) - 1;

  cntStrobe_t         strobe;
  logic [RANGE_W-1:0] torr;
  logic [CNT_W-1:0]   countVal;
  logic               countZero, enableQ, respModeQ, irqPendingQ;

  wdt_control #(
    .ADDR_W(ADDR_W), .RANGE_W(RANGE_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
  ) u_control (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .countVal(countVal), .countZero(countZero), .strobe(strobe), .torr(torr),
    .enable(enableQ), .respMode(respModeQ), .irqPending(irqPendingQ),
    .resetReq(resetReq)
  );

  wdt_datapath #(
    .BASE_SHIFT(BASE_SHIFT), .RANGE_W(RANGE_W), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .torr(torr),
    .countVal(countVal), .countZero(countZero)
  );

  assign irq = irqPendingQ;
endmodule

// File: rtl/wdt_two_stage_sva.sv
module wdt_two_stage_sva #(
  parameter int BASE_SHIFT = 16,
  parameter int RANGE_W    = 4,
  parameter int ADDR_W     = 8,
  parameter int PULSE_LEN  = 8,
  parameter int CNT_W      = 31
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [31:0]        busWrData,
  input logic               busRdEn,
  input logic               irq,
  input logic               resetReq,
  input logic               enable,
  input logic               respMode,
  input logic [RANGE_W-1:0] torr,
  input logic [CNT_W-1:0]   countVal
);
  function automatic logic [CNT_W-1:0] expLoad(input logic [RANGE_W-1:0] t);
    expLoad = CNT_W'((64'd1 << (BASE_SHIFT + int'(t))) - 64'd1);
  endfunction

  int runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else if (resetReq) runLen <= runLen + 1;
    else runLen <= 0;
  end

  logic isRestart, isEoi, quietBus;
  assign isRestart = busWrEn && (busAddr == ADDR_W'('h0C)) && (busWrData == 32'h76);
  assign isEoi     = busRdEn && (busAddr == ADDR_W'('h14));
  assign quietBus  = !busWrEn && !busRdEn;

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> enable); // R2
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!irq && !resetReq)); // R3
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (countVal == expLoad($past(torr)))); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !resetReq && countVal != '0 && quietBus) |=> (countVal == $past(countVal) - CNT_W'(1))); // R4
  AST_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rstN)
    (irq && respMode && enable && countVal == '0 && !resetReq && quietBus) |=> resetReq); // R6
  AST_IRQ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(respMode)); // R7
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (runLen < PULSE_LEN)); // R8
  AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetReq) |-> (runLen == PULSE_LEN)); // R8
  AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetReq) |-> !irq); // R8
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (isRestart && enable && !resetReq) |=> (countVal == expLoad($past(torr)))); // R9
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (isEoi && !resetReq) |=> !irq); // R10
endmodule

bind wdt_two_stage wdt_two_stage_sva #(
  .BASE_SHIFT(BASE_SHIFT), .RANGE_W(RANGE_W), .ADDR_W(ADDR_W),
  .PULSE_LEN(PULSE_LEN), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .irq(irq), .resetReq(resetReq),
  .enable(enableQ), .respMode(respModeQ), .torr(torr), .countVal(countVal)
);

// File: tb/test_wdt_two_stage.sv
`timescale 1ns/1ps
module test_wdt_two_stage;
  localparam int SHIFT = 2;
  localparam int PULSE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        irq, resetReq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int capCyc;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_two_stage #(.BASE_SHIFT(SHIFT), .PULSE_LEN(PULSE)) i_wdt_two_stage (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .irq(irq), .resetReq(resetReq)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #2 d = busRdData; capCyc = cyc;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic sweep(input bit mode, input int t);
    int p, n, bad, firstIrq, rstAt, width, holdBad;
    p = 1 << (SHIFT + t);
    doReset();
    busWrite(8'h04, 32'(t));
    busWrite(8'h00, mode ? 32'h3 : 32'h1);
    busAddr = 8'h08; busRdEn = 1'b1;
    #2;
    n = 0; bad = 0; firstIrq = -1; rstAt = -1;
    while (rstAt < 0 && n < 3 * p + 40) begin
      if (n < p && busRdData != 32'(p - 1 - n)) bad++;
      if (irq && firstIrq < 0) firstIrq = n;
      if (resetReq) rstAt = n;
      else begin
        @(negedge clk); #2; n++;
      end
    end
    check($sformatf("R4 count trace mode%0d range%0d", mode, t), bad, 0);
    if (mode) begin
      check($sformatf("R5 irq time range%0d", t), firstIrq, p);
      check($sformatf("R6 second-stage reset time range%0d", t), rstAt, 2 * p);
    end else begin
      check($sformatf("R7 direct reset time range%0d", t), rstAt, p);
      check($sformatf("R7 no irq range%0d", t), firstIrq, -1);
    end
    width = 0; holdBad = 0;
    while (resetReq && width < 4 * PULSE) begin
      if (busRdData != 32'(p - 1)) holdBad++;
      width++;
      @(negedge clk); #2;
    end
    check($sformatf("R8 pulse width mode%0d range%0d", mode, t), width, PULSE);
    check($sformatf("R8 count held in pulse mode%0d range%0d", mode, t), holdBad, 0);
    check($sformatf("R8 irq cleared after pulse mode%0d range%0d", mode, t), irq, 0);
    check($sformatf("R8 fresh period after pulse mode%0d range%0d", mode, t), busRdData, p - 1);
    busRdEn = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int cE, cR, n, sawAny;

    // R1 reset state
    doReset();
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    check("R1 resetReq after reset", resetReq, 0);
    busRead(8'h00, d); check("R1 control reads 0", d, 0);
    busRead(8'h04, d); check("R1 range reads 0", d, 0);
    busRead(8'h10, d); check("R1 status reads 0", d, 0);
    busRead(8'h08, d); check("R1 count reads 2^SHIFT-1", d, (1 << SHIFT) - 1);

    // R3 disabled: hold at live reload, never fire
    busWrite(8'h04, 32'h2);
    busWrite(8'h00, 32'h2);
    busRead(8'h08, d); check("R3 disabled count holds reload", d, 15);
    sawAny = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (irq || resetReq) sawAny++;
    end
    check("R3 no irq or reset while disabled", sawAny, 0);
    busRead(8'h08, d); check("R3 count still at reload", d, 15);
    busRead(8'h00, d); check("R12 mode bit reads back without enable", d, 2);
    busRead(8'h04, d); check("R12 range reads back", d, 2);

    // R2 sticky enable, R12 read-zero offsets
    busWrite(8'h00, 32'h1);
    busWrite(8'h00, 32'h0);
    busRead(8'h00, d); check("R2 enable survives clearing write", d, 1);
    busWrite(8'h00, 32'h2);
    busRead(8'h00, d); check("R2 mode writable while enabled", d, 3);
    busRead(8'h0C, d); check("R12 restart offset reads 0", d, 0);

    // R9 restart key
    doReset();
    busWrite(8'h04, 32'h4);
    busWrite(8'h00, 32'h1);
    cE = cyc;
    busWrite(8'h0C, 32'h75);
    busWrite(8'h0C, 32'h176);
    busRead(8'h08, d); check("R9 wrong key ignored", d, 63 - (capCyc - cE));
    busWrite(8'h0C, 32'h76);
    cR = cyc;
    busRead(8'h08, d); check("R9 key reloads count", d, 63 - (capCyc - cR));
    n = 0;
    while (!resetReq && n < 500) begin @(negedge clk); n++; end
    check("R9 expiry one period after key", cyc - cR, 64);

    // R11 deferred range change
    doReset();
    busWrite(8'h04, 32'h3);
    busWrite(8'h00, 32'h3);
    cE = cyc;
    busWrite(8'h04, 32'h1);
    busRead(8'h08, d); check("R11 running count unaffected", d, 31 - (capCyc - cE));
    busWrite(8'h0C, 32'h76);
    cR = cyc;
    busRead(8'h08, d); check("R11 new period after restart", d, 7 - (capCyc - cR));
    n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    check("R11 irq after new short period", cyc - cR, 8);

    // R10 end-of-interrupt
    doReset();
    busWrite(8'h04, 32'h2);
    busWrite(8'h00, 32'h3);
    n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    busRead(8'h10, d); check("R5 status bit0 set", d, 1);
    busRead(8'h14, d); check("R12 eoi offset reads 0", d, 0);
    cR = cyc;
    check("R10 irq dropped by eoi", irq, 0);
    busRead(8'h10, d); check("R10 status cleared", d, 0);
    busRead(8'h08, d); check("R10 count reloaded", d, 15 - (capCyc - cR));
    n = 0;
    while (!irq && !resetReq && n < 200) begin @(negedge clk); n++; end
    check("R10 next event is irq not reset", resetReq, 0);
    check("R10 irq one period after eoi", cyc - cR, 16);

    // R4..R8 sweeps over range and mode
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 10; t++) begin
        sweep(m[0], t);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule